// File: doc/BRIEF.md
# Prioritized Sixteen-Line Interrupt Controller

This block collects up to sixteen external interrupt request lines and presents one request to the processor. Each line is brought into the clock domain through a two-stage synchronizer. Each line then qualifies under a trigger mode of its own: active low, active high, falling edge or rising edge. Edge-mode lines set a sticky latch, and only an explicit clear command resets it. Each line also carries a 3-bit priority. Priority zero turns the line off. A global mask threshold suppresses every line whose priority does not exceed it.

The arbiter runs every cycle. Among the qualifying lines, the highest priority wins, and a tie goes to the lower line number. The winner and its priority are registered into a current-status word. The same evaluation drives the processor request output. Because the status is recomputed every cycle, software that rewrites the mask word after changing priorities always sees a refreshed winner.

Software reaches the block through a flat word-addressed 32-bit port. Writes take effect at the clock edge. Reads are combinational.

Top module: `prio_intc`

## Requirements
- R1: After reset, every word reads zero except the current-status word (word 40), which reads 0x0001_0000. The request output is low.
- R2: Word 0 bit 0 is the global enable. While it is clear, the request output stays low and the current-status word reads 0x0001_0000, whatever the inputs and other settings are.
- R3: Each line has a 2-bit trigger field. The codes are 00 active-low, 01 active-high, 10 falling edge and 11 rising edge. Line n's field sits in word 1 + n/8, at bits (n mod 8)*2+1 : (n mod 8)*2. These fields read back as written.
- R4: Line n's priority sits in word 4 + n/2, at bits 2:0 for even n and bits 10:8 for odd n. Other bits of these words read zero. A priority of 0 never produces a request.
- R5: After an input change on a level-mode line, the request output and the current-status word reflect it on the third rising clock edge.
- R6: An edge-mode line latches its selected transition. It stays pending after the input returns to its idle value.
- R7: A write to word 24 with bit 8 set clears the edge latch of the line numbered in bits 3:0. A write with bit 8 clear changes nothing.
- R8: A line is reported only if its priority is strictly greater than the mask in word 16 bits 2:0. The next evaluation after a mask write uses the new mask.
- R9: Among reportable lines, the highest priority wins. Equal priorities go to the lowest line number.
- R10: In the current-status word, bit 16 reads 1 when nothing is reportable, bits 10:8 hold the winning priority, and bits 4:0 hold the winning line number. The request output is high exactly when bit 16 is 0.
- R11: Word 32 bit n reads 1 when line n is asserted under its trigger mode, before priority and mask are applied.
- R12: Words not listed above read zero and ignore writes. Word 0 keeps only bit 0, and word 16 keeps only bits 2:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | 16 | Asynchronous interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_out | output | 1 | Request to the processor |

## Verification
The assertions assume that a clear command and a new edge on the same line do not arrive in one cycle. In that case the latch keeps the new edge. They also assume that the processor only issues writes with the line number in bits 3:0. The stimulus changes request lines only while no clear is being written, and it waits several cycles after each change before the next write. This keeps every edge distinct from the clear command that follows it. The priority sweeps hold all lines in active-high mode, so the line-activity word equals the driven input pattern.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RISE = 2'b11
    } trig_e;

    localparam int W_ENABLE = 0;
    localparam int W_MODE0  = 1;
    localparam int W_LVL0   = 4;
    localparam int W_MASK   = 16;
    localparam int W_CLEAR  = 24;
    localparam int W_ACTIVE = 32;
    localparam int W_CUR    = 40;

    localparam int CLR_FIRE_BIT = 8;
    localparam int NONE_BIT     = 16;
    localparam int CUR_LVL_LSB  = 8;

endpackage

// File: rtl/prio_intc_sync.sv
module prio_intc_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/prio_intc_edge.sv
module prio_intc_edge #(
    parameter int NUM_SRC = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       line,
    input  logic [NUM_SRC-1:0][1:0]  mode,
    input  logic [NUM_SRC-1:0]       clr_hit,
    output logic [NUM_SRC-1:0]       latch,
    output logic [NUM_SRC-1:0]       active
);
    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
        logic [NUM_SRC-1:0] lat;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = line;
        for (int i = 0; i < NUM_SRC; i++) begin
            logic rise, fall, set;
            rise = line[i] & ~st_q.prev[i];
            fall = ~line[i] & st_q.prev[i];
            set  = mode[i][1] & (mode[i][0] ? rise : fall);
            // a new edge in the clearing cycle is kept
            st_d.lat[i] = (st_q.lat[i] & ~clr_hit[i]) | set;
            if (mode[i][1]) active[i] = st_q.lat[i];
            else            active[i] = mode[i][0] ? line[i] : ~line[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch = st_q.lat;
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb #(
    parameter int NUM_SRC = 16,
    parameter int LVL_W   = 3,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]            active,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0]              mask,
    output logic                          found,
    output logic [LVL_W-1:0]              win_lvl,
    output logic [SRC_W-1:0]              win_src
);
    always_comb begin
        found   = 1'b0;
        win_lvl = mask;
        win_src = '0;
        // strict compare while scanning upward keeps the lowest index on ties
        for (int i = 0; i < NUM_SRC; i++) begin
            if (active[i] && (lvl[i] > win_lvl)) begin
                found   = 1'b1;
                win_lvl = lvl[i];
                win_src = SRC_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC     = 16,
    parameter int LVL_W       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 32,
    localparam int SRC_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_out
);
    typedef struct packed {
        logic                           en;
        logic [NUM_SRC-1:0][1:0]        mode;
        logic [NUM_SRC-1:0][LVL_W-1:0]  lvl;
        logic [LVL_W-1:0]               mask;
        logic                           irq;
        logic                           none;
        logic [LVL_W-1:0]               cur_lvl;
        logic [SRC_W-1:0]               cur_src;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0] line_s;
    logic [NUM_SRC-1:0] edge_lat;
    logic [NUM_SRC-1:0] src_active;
    logic [NUM_SRC-1:0] clr_hit;
    logic               arb_found;
    logic [LVL_W-1:0]   arb_lvl;
    logic [SRC_W-1:0]   arb_src;
    logic               unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:16];

    prio_intc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(req_in), .q(line_s)
    );

    prio_intc_edge #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk(clk), .rst_n(rst_n), .line(line_s), .mode(st_q.mode),
        .clr_hit(clr_hit), .latch(edge_lat), .active(src_active)
    );

    prio_intc_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_arb (
        .active(src_active), .lvl(st_q.lvl), .mask(st_q.mask),
        .found(arb_found), .win_lvl(arb_lvl), .win_src(arb_src)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            clr_hit[i] = wr_en && (addr == ADDR_W'(W_CLEAR))
                         && wdata[CLR_FIRE_BIT] && (wdata[3:0] == 4'(i));
        end
        if (wr_en) begin
            if (addr == ADDR_W'(W_ENABLE)) st_d.en   = wdata[0];
            if (addr == ADDR_W'(W_MASK))   st_d.mask = wdata[LVL_W-1:0];
            for (int i = 0; i < NUM_SRC; i++) begin
                if (addr == ADDR_W'(W_MODE0 + i / 8))
                    st_d.mode[i] = wdata[(i % 8) * 2 +: 2];
                if (addr == ADDR_W'(W_LVL0 + i / 2))
                    st_d.lvl[i] = wdata[(i % 2) * 8 +: LVL_W];
            end
        end
        st_d.irq     = st_q.en & arb_found;
        st_d.none    = ~(st_q.en & arb_found);
        st_d.cur_lvl = (st_q.en & arb_found) ? arb_lvl : '0;
        st_d.cur_src = (st_q.en & arb_found) ? arb_src : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.none <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(W_ENABLE)) rdata[0] = st_q.en;
        if (addr == ADDR_W'(W_MASK))   rdata[LVL_W-1:0] = st_q.mask;
        if (addr == ADDR_W'(W_ACTIVE)) rdata[NUM_SRC-1:0] = src_active;
        if (addr == ADDR_W'(W_CUR)) begin
            rdata[NONE_BIT]                 = st_q.none;
            rdata[CUR_LVL_LSB +: LVL_W]     = st_q.cur_lvl;
            rdata[SRC_W-1:0]                = st_q.cur_src;
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (addr == ADDR_W'(W_MODE0 + i / 8))
                rdata[(i % 8) * 2 +: 2] = st_q.mode[i];
            if (addr == ADDR_W'(W_LVL0 + i / 2))
                rdata[(i % 2) * 8 +: LVL_W] = st_q.lvl[i];
        end
    end

    assign irq_out = st_q.irq;
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
    parameter int NUM_SRC = 16,
    parameter int LVL_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_out,
    input logic               glob_en,
    input logic [LVL_W-1:0]   mask_lvl,
    input logic [LVL_W-1:0]   cur_lvl,
    input logic               cur_none,
    input logic [NUM_SRC-1:0] edge_lat,
    input logic [NUM_SRC-1:0] clr_hit
);
    AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> !irq_out); // R2

    AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (!irq_out || cur_lvl > $past(mask_lvl))); // R8

    AST_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (cur_lvl != '0)); // R4

    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out != cur_none); // R10

    AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_hit)); // R7

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_hold
        AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            edge_lat[g] && !clr_hit[g] |=> edge_lat[g]); // R6
    end
endmodule

bind prio_intc prio_intc_chk #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .glob_en(st_q.en),
    .mask_lvl(st_q.mask), .cur_lvl(st_q.cur_lvl), .cur_none(st_q.none),
    .edge_lat(edge_lat), .clr_hit(clr_hit)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_in = 16'hFFFF;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    prio_intc u_prio_intc (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = 6'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = 6'(a);
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    function automatic logic [31:0] cur_word(input logic f, input int lv, input int src);
        return f ? {16'h0000, 5'd0, 3'(lv), 3'd0, 5'(src)} : 32'h0001_0000;
    endfunction

    task automatic check_cur(input string tag, input logic f, input int lv, input int src);
        logic [31:0] d;
        rd(40, d);
        check(tag, d, cur_word(f, lv, src));
        check(tag, {31'd0, irq_out}, {31'd0, f});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [2:0]  lv [16];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset image
        check("R1 irq", {31'd0, irq_out}, 32'd0);
        for (int w = 0; w < 64; w++) begin
            rd(w, d);
            check("R1 word", d, (w == 40) ? 32'h0001_0000 : 32'h0);
        end

        // R12 / R3 / R4 readback and reserved words
        wr(3, 32'hFFFF_FFFF);  rd(3, d);  check("R12 reserved", d, 0);
        wr(50, 32'hFFFF_FFFF); rd(50, d); check("R12 reserved", d, 0);
        wr(24, 32'h0000_0000); rd(24, d); check("R12 clear word reads 0", d, 0);
        wr(0, 32'hFFFF_FFFE);  rd(0, d);  check("R12 enable bits", d, 0);
        wr(16, 32'hFFFF_FFFF); rd(16, d); check("R12 mask bits", d, 32'h7);
        wr(1, 32'hFFFF_FFFF);  rd(1, d);  check("R3 mode word1", d, 32'h0000_FFFF);
        wr(2, 32'h0000_9C63);  rd(2, d);  check("R3 mode word2", d, 32'h0000_9C63);
        wr(4, 32'hFFFF_FFFF);  rd(4, d);  check("R4 level slots", d, 32'h0000_0707);
        wr(1, 0); wr(2, 0); wr(4, 0); wr(16, 0);

        // R2 enable gating: line 3 active-high, level 5
        wr(1, 32'h0000_0040);
        wr(5, 32'h0000_0500);
        settle();
        check_cur("R2 disabled", 1'b0, 0, 0);
        wr(0, 1);
        settle();
        check_cur("R2 enabled", 1'b1, 5, 3);

        // R8 strict mask compare and mask-write refresh
        wr(16, 5); settle(); check_cur("R8 equal masked", 1'b0, 0, 0);
        wr(16, 0); wr(16, 4); settle(); check_cur("R8 below passes", 1'b1, 5, 3);
        wr(16, 0);

        // R4 level zero disables
        wr(5, 0); settle(); check_cur("R4 level zero", 1'b0, 0, 0);

        // R5 latency: line 3 level 2, toggle input, sample edges
        wr(5, 32'h0000_0200);
        req_in[3] = 1'b0;
        settle();
        check_cur("R5 idle", 1'b0, 0, 0);
        @(negedge clk); req_in[3] = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R5 not before edge 3", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        check("R5 at edge 3", {31'd0, irq_out}, 32'd1);

        // R3 active-low mode on line 3
        wr(1, 32'h0000_0000);
        settle(); check_cur("R3 low mode idle high", 1'b0, 0, 0);
        rd(32, d); check("R11 low mode inactive", d, 0);
        req_in[3] = 1'b0; settle();
        check_cur("R3 low mode asserted", 1'b1, 2, 3);
        rd(32, d); check("R11 low mode active", d, 32'h0000_0008);
        req_in[3] = 1'b1; wr(5, 0);

        // R9 / R11 sweep: all lines active-high
        wr(1, 32'h0000_5555); wr(2, 32'h0000_5555);
        for (int p = 0; p < 48; p++) begin
            logic [15:0] pat;
            int mk, best, bsrc;
            logic fnd;
            pat = 16'((p * 40503) ^ (p * 7));
            if (p == 47) pat = 16'hFFFF;
            mk = p % 5;
            for (int i = 0; i < 16; i++) lv[i] = 3'((i * 5 + p * 3) % 8);
            if (p >= 45) for (int i = 0; i < 16; i++) lv[i] = 3'd4;
            req_in = pat;
            for (int k = 0; k < 8; k++)
                wr(4 + k, {21'd0, lv[2*k+1], 5'd0, lv[2*k]});
            wr(16, mk);
            settle();
            best = mk; bsrc = 0; fnd = 1'b0;
            for (int i = 0; i < 16; i++)
                if (pat[i] && int'(lv[i]) > best) begin
                    best = int'(lv[i]); bsrc = i; fnd = 1'b1;
                end
            check_cur("R9 priority sweep", fnd, best, bsrc);
            rd(32, d); check("R11 active word", d, {16'd0, pat});
        end
        req_in = 16'hFFFF;
        for (int k = 0; k < 8; k++) wr(4 + k, 0);
        wr(16, 0); wr(1, 0); wr(2, 0);

        // R6 / R7 edge latches: line 5 rising lvl 6, line 9 falling lvl 3
        req_in[5] = 1'b0;
        wr(1, 32'h0000_0C00); wr(2, 32'h0000_0008);
        wr(6, 32'h0000_0600); wr(8, 32'h0000_0300);
        settle();
        check_cur("R6 no edge yet", 1'b0, 0, 0);
        req_in[5] = 1'b1; settle();
        check_cur("R6 rising latched", 1'b1, 6, 5);
        req_in[5] = 1'b0; settle();
        check_cur("R6 held after return", 1'b1, 6, 5);
        rd(32, d); check("R11 latch visible", d, 32'h0000_0020);
        wr(24, 32'h0000_0005); settle();
        check_cur("R7 no fire bit", 1'b1, 6, 5);
        wr(24, 32'h0000_0105); settle();
        check_cur("R7 cleared", 1'b0, 0, 0);
        req_in[9] = 1'b0; settle();
        check_cur("R6 falling latched", 1'b1, 3, 9);
        req_in[5] = 1'b1; settle();
        check_cur("R9 higher edge wins", 1'b1, 6, 5);
        wr(24, 32'h0000_0105); settle();
        check_cur("R7 other latch kept", 1'b1, 3, 9);
        wr(24, 32'h0000_0109); settle();
        check_cur("R7 all cleared", 1'b0, 0, 0);

        // R2 disabling again silences pending edge
        req_in[9] = 1'b1; settle(); req_in[9] = 1'b0; settle();
        wr(0, 0); settle();
        check_cur("R2 re-disabled", 1'b0, 0, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule